// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block runs single-word program and whole-sector erase operations on a parallel NOR flash that sits on an asynchronous memory bus. A client places an operation type, a word address and, for a program, a data word on the request inputs and pulses start. The block then owns the flash bus until the operation ends with a one-cycle done pulse and an error flag.

Each operation begins with the flash's unlock handshake and command writes. Completion is found by reading the target location twice in a row and comparing bit 6 of the two results: while the device is busy, that bit flips on every read. The operation ends with a readback check. After a program, the written word must read back unchanged. After an erase, every word of the sector must read as all ones. Polling is bounded by a separate limit for program and for erase. Each bus access is timed by a small strobe generator with a parameterised pulse length and recovery gap.

Top module: `nor_pe_seq`

## Requirements
- R1: A program issues exactly four bus writes in this order: 0xAA to word 0x555, 0x55 to word 0x2AA, 0xA0 to word 0x555, and then the request data to the request word address.
- R2: An erase issues exactly six bus writes in this order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and then 0x30 to the sector base. The sector base is the request address with its low SECT_W bits cleared. Command bytes occupy bits 7:0, and the upper data bits are zero.
- R3: The byte address on the bus is the word address multiplied by DATA_W/8. With a 16-bit bus, word 0x555 appears as byte 0xAAA.
- R4: After the command writes, the block reads the target word in pairs (the sector base for an erase). A pair whose bit 6 values differ is a busy check, and the block reads another pair. The first pair that agrees ends polling. A device that is already ready therefore costs exactly two poll reads.
- R5: A program whose polling sees PROG_POLL_MAX busy checks ends with err=1, after exactly 2*PROG_POLL_MAX poll reads and no verify read.
- R6: An erase whose polling sees ERASE_POLL_MAX busy checks ends with err=1, after exactly 2*ERASE_POLL_MAX poll reads.
- R7: After program polling, the block reads the target word once. err is 1 exactly when that value differs from the written data.
- R8: After erase polling, the block reads the sector words from the base upward. It stops with err=1 at the first word that is not all ones. If all 2^SECT_W words are all ones, it ends with err=0.
- R9: vppEn rises together with the first bus strobe of an operation, stays high through the done cycle and is low in the following cycle. It is never low while the chip enable is active.
- R10: done is high for exactly one cycle per operation, and busy is low in the cycle after done. A start that arrives while busy is high is ignored and causes no bus activity afterwards.
- R11: Write enable and output enable are never active together. Either strobe active implies chip enable active. The bus address is stable for the whole time chip enable stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Start pulse, accepted only while idle |
| reqErase | input | 1 | 1 = sector erase, 0 = word program |
| reqAddr | input | ADDR_W | Target word address |
| reqData | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation failed (timeout or verify); valid with done, held until next start |
| flAddr | output | ADDR_W+log2(DATA_W/8) | Flash byte address |
| flDout | output | DATA_W | Write data to the flash |
| flDin | input | DATA_W | Read data from the flash |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |
| vppEn | output | 1 | Programming voltage / write-protect release |

## Verification
A wrong step counter or a wrong command table shows up within the first few bus writes. It appears as a wrong byte or a wrong address in the write log, or as a wrong number of writes before polling begins. A poll counter that compares against the wrong limit, or that misses a clear, changes the exact number of read strobes seen on the bus before done, so the error is visible at the end of the operation. A verify counter that skips a word or runs past the sector shows up in the read count of an erase, and so does a verify that continues after a mismatch. An enable flag held or dropped on the wrong cycle is caught in the cycle right after done.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {A_UNLK1, A_UNLK2, A_TGT, A_VER} addr_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} seq_state_e;
  typedef enum logic [1:0] {PH_CMD, PH_POLLA, PH_POLLB, PH_VER} seq_phase_e;

  typedef struct packed {
    logic      latch;
    logic      go;
    logic      wr;
    addr_sel_e asel;
    logic      useWord;
    logic [7:0] cmdByte;
    logic      clrPoll;
    logic      incPoll;
    logic      clrVer;
    logic      incVer;
  } seq_ctl_t;

  localparam logic [10:0] UNLK1_OFS = 11'h555;
  localparam logic [10:0] UNLK2_OFS = 11'h2AA;
  localparam logic [7:0]  CMD_KEY1  = 8'hAA;
  localparam logic [7:0]  CMD_KEY2  = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERS1  = 8'h80;
  localparam logic [7:0]  CMD_ERS2  = 8'h30;
endpackage

// File: rtl/nor_seq_strobe.sv
module nor_seq_strobe #(
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic go,
  output logic active,
  output logic capture,
  output logic fin
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PLAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GLAST = CW'(GAP_CYC - 1);

  logic inGap;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      inGap  <= 1'b0;
      cnt    <= '0;
    end else if (go && !active && !inGap) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == PLAST) begin
        active <= 1'b0;
        inGap  <= 1'b1;
        cnt    <= '0;
      end else cnt <= cnt + 1'b1;
    end else if (inGap) begin
      if (cnt == GLAST) inGap <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign capture = active && (cnt == PLAST);
  assign fin     = inGap && (cnt == GLAST);
endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4,
  parameter int PROG_POLL_MAX  = 500000,
  parameter int ERASE_POLL_MAX = 50000000,
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 1,
  parameter int BA_W = ADDR_W + $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] flDin,
  output logic [BA_W-1:0]   flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              cycDone,
  output logic              bit6Diff,
  output logic              verOk,
  output logic              pollExpired,
  output logic              verLast
);
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int MAXP = (PROG_POLL_MAX > ERASE_POLL_MAX) ? PROG_POLL_MAX : ERASE_POLL_MAX;
  localparam int PCW  = $clog2(MAXP + 1);
  localparam logic [PCW-1:0] PLIM = PCW'(PROG_POLL_MAX - 1);
  localparam logic [PCW-1:0] ELIM = PCW'(ERASE_POLL_MAX - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_W) - 1);

  logic [ADDR_W-1:0] tgtAddr, busAddr, sectBase, selAddr;
  logic [DATA_W-1:0] wData, rdReg;
  logic isErase, curWr, prevBit6, active, capture;
  logic [SECT_W-1:0] verIdx;
  logic [PCW-1:0]    pollCnt;

  assign sectBase = tgtAddr & ~SECT_MASK;

  always_comb begin
    unique case (ctl.asel)
      A_UNLK1: selAddr = ADDR_W'(UNLK1_OFS);
      A_UNLK2: selAddr = ADDR_W'(UNLK2_OFS);
      A_TGT:   selAddr = isErase ? sectBase : tgtAddr;
      default: selAddr = isErase ? (sectBase | ADDR_W'(verIdx)) : tgtAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr  <= '0;
      wData    <= '0;
      isErase  <= 1'b0;
      busAddr  <= '0;
      flDout   <= '0;
      curWr    <= 1'b0;
      rdReg    <= '0;
      prevBit6 <= 1'b0;
      verIdx   <= '0;
      pollCnt  <= '0;
    end else begin
      if (ctl.latch) begin
        tgtAddr <= reqAddr;
        wData   <= reqData;
        isErase <= reqErase;
      end
      if (ctl.go) begin
        busAddr <= selAddr;
        flDout  <= ctl.useWord ? wData : DATA_W'(ctl.cmdByte);
        curWr   <= ctl.wr;
      end
      if (capture && !curWr) begin
        prevBit6 <= rdReg[6];
        rdReg    <= flDin;
      end
      if (ctl.clrPoll) pollCnt <= '0;
      else if (ctl.incPoll) pollCnt <= pollCnt + 1'b1;
      if (ctl.clrVer) verIdx <= '0;
      else if (ctl.incVer) verIdx <= verIdx + 1'b1;
    end
  end

  nor_seq_strobe #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_strb (
    .clk(clk), .rstN(rstN), .go(ctl.go),
    .active(active), .capture(capture), .fin(cycDone)
  );

  assign flAddr      = BA_W'(busAddr) << BYTE_SHIFT;
  assign flCeN       = !active;
  assign flWeN       = !(active && curWr);
  assign flOeN       = !(active && !curWr);
  assign bit6Diff    = rdReg[6] ^ prevBit6;
  assign verOk       = isErase ? (rdReg == '1) : (rdReg == wData);
  assign pollExpired = pollCnt == (isErase ? ELIM : PLIM);
  assign verLast     = verIdx == '1;
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqStart,
  input  logic     reqErase,
  input  logic     cycDone,
  input  logic     bit6Diff,
  input  logic     verOk,
  input  logic     pollExpired,
  input  logic     verLast,
  output seq_ctl_t ctl,
  output logic     busy,
  output logic     done,
  output logic     err,
  output logic     vppEn
);
  seq_state_e state;
  seq_phase_e phase;
  logic [2:0] step;
  logic opErase;
  logic lastStep;
  addr_sel_e  tblAsel;
  logic [7:0] tblByte;
  logic       tblWord;

  assign lastStep = step == (opErase ? 3'd5 : 3'd3);

  always_comb begin
    tblAsel = A_UNLK1;
    tblByte = CMD_KEY1;
    tblWord = 1'b0;
    case (step)
      3'd0: ;
      3'd1: begin tblAsel = A_UNLK2; tblByte = CMD_KEY2; end
      3'd2: tblByte = opErase ? CMD_ERS1 : CMD_PROG;
      3'd3: if (!opErase) begin tblAsel = A_TGT; tblWord = 1'b1; end
      3'd4: begin tblAsel = A_UNLK2; tblByte = CMD_KEY2; end
      default: begin tblAsel = A_TGT; tblByte = CMD_ERS2; end
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.asel = A_UNLK1;
    if (state == ST_IDLE && reqStart) ctl.latch = 1'b1;
    if (state == ST_ISSUE) begin
      ctl.go      = 1'b1;
      ctl.wr      = phase == PH_CMD;
      ctl.asel    = (phase == PH_CMD) ? tblAsel : (phase == PH_VER) ? A_VER : A_TGT;
      ctl.cmdByte = tblByte;
      ctl.useWord = (phase == PH_CMD) && tblWord;
    end
    if (state == ST_WAIT && cycDone) begin
      ctl.clrPoll = (phase == PH_CMD) && lastStep;
      ctl.incPoll = (phase == PH_POLLB) && bit6Diff && !pollExpired;
      ctl.clrVer  = (phase == PH_POLLB) && !bit6Diff;
      ctl.incVer  = (phase == PH_VER) && verOk && opErase && !verLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_CMD;
      step    <= '0;
      opErase <= 1'b0;
      err     <= 1'b0;
      vppEn   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqStart) begin
          opErase <= reqErase;
          step    <= '0;
          phase   <= PH_CMD;
          err     <= 1'b0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: begin
          vppEn <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: if (cycDone) begin
          state <= ST_ISSUE;
          unique case (phase)
            PH_CMD:   if (lastStep) phase <= PH_POLLA; else step <= step + 1'b1;
            PH_POLLA: phase <= PH_POLLB;
            PH_POLLB: if (!bit6Diff) phase <= PH_VER;
                      else if (pollExpired) begin err <= 1'b1; state <= ST_FIN; end
                      else phase <= PH_POLLA;
            default:  if (!verOk) begin err <= 1'b1; state <= ST_FIN; end
                      else if (!opErase || verLast) state <= ST_FIN;
          endcase
        end
        default: begin
          vppEn <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = state != ST_IDLE;
  assign done = state == ST_FIN;
endmodule

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4,
  parameter int PROG_POLL_MAX  = 500000,
  parameter int ERASE_POLL_MAX = 50000000,
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 1,
  localparam int BA_W = ADDR_W + $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [BA_W-1:0]   flAddr,
  output logic [DATA_W-1:0] flDout,
  input  logic [DATA_W-1:0] flDin,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              vppEn
);
  seq_ctl_t ctl;
  logic cycDone, bit6Diff, verOk, pollExpired, verLast;

  nor_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqErase(reqErase),
    .cycDone(cycDone), .bit6Diff(bit6Diff), .verOk(verOk),
    .pollExpired(pollExpired), .verLast(verLast), .ctl(ctl),
    .busy(busy), .done(done), .err(err), .vppEn(vppEn)
  );

  nor_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_POLL_MAX(PROG_POLL_MAX), .ERASE_POLL_MAX(ERASE_POLL_MAX),
    .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC), .BA_W(BA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqData(reqData), .flDin(flDin),
    .flAddr(flAddr), .flDout(flDout), .flCeN(flCeN), .flOeN(flOeN),
    .flWeN(flWeN), .cycDone(cycDone), .bit6Diff(bit6Diff), .verOk(verOk),
    .pollExpired(pollExpired), .verLast(verLast)
  );
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int BA_W = 21,
  parameter int BYTE_SHIFT = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            vppEn,
  input logic            flCeN,
  input logic            flOeN,
  input logic            flWeN,
  input logic [BA_W-1:0] flAddr
);
  localparam logic [BA_W-1:0] LOW_MASK = BA_W'((1 << BYTE_SHIFT) - 1);

  a_r11_we_oe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN));
  a_r11_strobe_ce: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN || !flOeN) |-> !flCeN);
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!flCeN && $past(!flCeN)) |-> $stable(flAddr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r9_vpp_with_ce: assert property (@(posedge clk) disable iff (!rstN)
    !flCeN |-> vppEn);
  a_r9_vpp_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !vppEn);
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rstN)
    !flCeN |-> ((flAddr & LOW_MASK) == '0));
endmodule

bind nor_pe_seq nor_seq_chk #(.BA_W(BA_W), .BYTE_SHIFT($clog2(DATA_W / 8))) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .vppEn(vppEn),
  .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .flAddr(flAddr)
);

// File: tb/sim_nor_pe_seq.sv
module sim_nor_pe_seq;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int PMAX = 20;
  localparam int EMAX = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0, reqErase = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic busy, done, err, flCeN, flOeN, flWeN, vppEn;
  logic [AW:0] flAddr;
  logic [DW-1:0] flDout;
  logic [DW-1:0] flDin = '0;

  always #10 clk = ~clk;

  nor_pe_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .PROG_POLL_MAX(PMAX),
    .ERASE_POLL_MAX(EMAX), .PULSE_CYC(2), .GAP_CYC(1)) u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done), .err(err),
    .flAddr(flAddr), .flDout(flDout), .flDin(flDin), .flCeN(flCeN),
    .flOeN(flOeN), .flWeN(flWeN), .vppEn(vppEn));

  int nChk = 0, nFail = 0, cyc = 0;

  // flash model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW:0]   logA [0:15];
  logic [DW-1:0] logD [0:15];
  int wrCnt = 0, rdCnt = 0, busyLeft = 0, busyLoad = 0, doneCnt = 0;
  logic progArm = 1'b0, tog = 1'b0;
  logic [AW-1:0] faultAddr = '1;
  logic [DW-1:0] faultMask = '1;
  int vppBad = 0;

  always @(posedge flWeN) if (rstN) begin
    logic [AW-1:0] wa;
    wa = flAddr[AW:1];
    if (wrCnt < 16) begin logA[wrCnt] = flAddr; logD[wrCnt] = flDout; end
    wrCnt++;
    if (progArm) begin
      mem[wa] = mem[wa] & flDout; progArm = 1'b0; busyLeft = busyLoad;
    end else if (flDout == 16'h00A0 && wa == 12'h555) progArm = 1'b1;
    else if (flDout == 16'h0030) begin
      for (int i = 0; i < (1 << SW); i++) mem[{wa[AW-1:SW], SW'(i)}] = '1;
      busyLeft = busyLoad;
    end
  end

  always @(negedge flOeN) if (rstN) begin
    logic [AW-1:0] wa;
    wa = flAddr[AW:1];
    rdCnt++;
    if (busyLeft > 0) begin
      busyLeft--; tog = ~tog; flDin = {9'h0, tog, 6'h0};
    end else flDin = mem[wa] & ((wa == faultAddr) ? faultMask : '1);
  end

  always @(negedge clk) if (rstN) begin
    if (!flCeN && !vppEn) vppBad++;
    if (done) doneCnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++; nChk++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic clearModel(input int load);
    wrCnt = 0; rdCnt = 0; busyLeft = 0; busyLoad = load; progArm = 1'b0;
    faultAddr = '1; faultMask = '1; vppBad = 0; doneCnt = 0;
  endtask

  // starts op, waits for done; returns err, checks done/busy/vpp timing (R9, R10)
  task automatic runOp(input logic ers, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic gotErr);
    int n;
    @(negedge clk);
    reqErase = ers; reqAddr = a; reqData = d; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    gotErr = err;
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(vppEn == 1'b1, "R9 vppEn during done", vppEn, 1);
    @(negedge clk);
    chk(!done && !busy, "R10 done one cycle, busy low after", {done, busy}, 0);
    chk(vppEn == 1'b0, "R9 vppEn low after done", vppEn, 0);
    chk(vppBad == 0, "R9 vppEn high whenever CE low", vppBad, 0);
  endtask

  task automatic expWr(input int idx, input logic [AW:0] a, input logic [DW-1:0] d, input string tag);
    chk(logA[idx] == a && logD[idx] == d, tag, {logA[idx], logD[idx]}, {a, d});
  endtask

  task automatic testReset;
    chk(!busy && !done && flCeN && flOeN && flWeN && !vppEn, "R10 reset idle outputs",
        {busy, done, flCeN, flOeN, flWeN, vppEn}, 6'b001110);
  endtask

  task automatic testProgram;
    logic e;
    clearModel(6);
    mem[12'h123] = '1;
    runOp(1'b0, 12'h123, 16'h5A3C, e);
    chk(wrCnt == 4, "R1 program write count", wrCnt, 4);
    expWr(0, 13'hAAA, 16'h00AA, "R1 write0");
    expWr(1, 13'h554, 16'h0055, "R1 write1");
    expWr(2, 13'hAAA, 16'h00A0, "R1 write2");
    expWr(3, 13'h246, 16'h5A3C, "R3 data write at scaled byte address");
    chk(rdCnt == 9, "R4 program poll+verify reads", rdCnt, 9);
    chk(e == 1'b0, "R7 program verify pass", e, 0);
  endtask

  task automatic testReadyAtOnce;
    logic e;
    clearModel(0);
    mem[12'h010] = '1;
    runOp(1'b0, 12'h010, 16'h1234, e);
    chk(rdCnt == 3, "R4 ready device costs two poll reads", rdCnt, 3);
    chk(e == 1'b0, "R4 no error when ready at once", e, 0);
  endtask

  task automatic testErase;
    logic e;
    clearModel(6);
    for (int i = 0; i < 16; i++) mem[12'h340 + i] = '0;
    runOp(1'b1, 12'h347, 16'h0000, e);
    chk(wrCnt == 6, "R2 erase write count", wrCnt, 6);
    expWr(2, 13'hAAA, 16'h0080, "R2 write2");
    expWr(3, 13'hAAA, 16'h00AA, "R2 write3");
    expWr(4, 13'h554, 16'h0055, "R2 write4");
    expWr(5, 13'h680, 16'h0030, "R2 sector base write");
    chk(rdCnt == 24, "R8 erase reads whole sector", rdCnt, 24);
    chk(e == 1'b0, "R8 erase verify pass", e, 0);
  endtask

  task automatic testProgVerifyFail;
    logic e;
    clearModel(4);
    mem[12'h200] = '1;
    faultAddr = 12'h200; faultMask = 16'hFFFE;
    runOp(1'b0, 12'h200, 16'h0001, e);
    chk(e == 1'b1, "R7 program readback mismatch flags err", e, 1);
    chk(rdCnt == 7, "R7 single verify read", rdCnt, 7);
  endtask

  task automatic testEraseVerifyFail;
    logic e;
    clearModel(2);
    faultAddr = 12'h345; faultMask = 16'h7FFF;
    runOp(1'b1, 12'h34A, 16'h0000, e);
    chk(e == 1'b1, "R8 erase mismatch flags err", e, 1);
    chk(rdCnt == 10, "R8 verify stops at first bad word", rdCnt, 10);
  endtask

  task automatic testProgTimeout;
    logic e;
    clearModel(1000000);
    runOp(1'b0, 12'h050, 16'hBEEF, e);
    chk(e == 1'b1, "R5 program timeout err", e, 1);
    chk(rdCnt == 2 * PMAX, "R5 program poll read count", rdCnt, 2 * PMAX);
  endtask

  task automatic testEraseTimeout;
    logic e;
    clearModel(1000000);
    runOp(1'b1, 12'h0A0, 16'h0000, e);
    chk(e == 1'b1, "R6 erase timeout err", e, 1);
    chk(rdCnt == 2 * EMAX, "R6 erase poll read count", rdCnt, 2 * EMAX);
  endtask

  task automatic testStartWhileBusy;
    logic e;
    clearModel(20);
    mem[12'h077] = '1;
    @(negedge clk);
    reqErase = 1'b0; reqAddr = 12'h077; reqData = 16'h0F0F; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    repeat (10) @(negedge clk);
    reqErase = 1'b1; reqAddr = 12'h300; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
    e = err;
    repeat (30) @(negedge clk);
    chk(!busy && doneCnt == 1, "R10 start while busy ignored (one op)", doneCnt, 1);
    chk(wrCnt == 4, "R10 no extra bus writes", wrCnt, 4);
    chk(e == 1'b0 && mem[12'h077] == 16'h0F0F, "R10 first op intact", mem[12'h077], 16'h0F0F);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '1;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testProgram();
    testReadyAtOnce();
    testErase();
    testProgVerifyFail();
    testEraseVerifyFail();
    testProgTimeout();
    testEraseTimeout();
    testStartWhileBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule